// File: doc/BRIEF.md
# Interrupt Line Aggregator with Message Output

This block gathers eleven level-sensitive interrupt lines into one register-bus target and turns changes on them into posted write messages. Each line is synchronised into the clock domain. A rising level on a line that is enabled in the mask register is recorded in two sticky registers. One is the request register, which a read returns and clears. The other is the pending register, which a read also clears. A live register shows the synchronised lines directly and is never cleared.

When any enabled line rises and the block is switched on, the block raises one message on a valid/ready output. The message carries an address and a data value taken from a single target word. The low `MSG_DATA_W` bits of that word form the data and the remaining bits form the address. The address and data are captured when the message is raised. They stay stable until the receiver takes the message. While a message waits, new edges are not queued as extra messages; they only collect in the request register. Software finds them there when it reads the request register. An edge that arrives in the same cycle as an accepted handshake starts the next message.

Register access is a one-cycle strobe. `reg_sel` is sampled at a rising clock edge, and `reg_wr` picks write or read. Read data appears on `reg_rdata` one cycle later and holds until the next read.

Top module: `irq_gather`

## Requirements
- R1: After reset every register reads zero and `msg_valid` is low.
- R2: The live register (offset 0x028) shows the synchronised input lines no more than three clock edges after a change, regardless of the mask. Line 9 is not implemented: it reads 0 in the live, mask, request and pending registers, and it never raises a message.
- R3: When the control register (offset 0x024) has bit 0 set and line n rises while mask bit n (offset 0x018) is set, bit n is set in both the request register (offset 0x00C) and the pending register (offset 0x01C). A message is then raised. Its `msg_addr` is the target word (offset 0x004) with bits [MSG_DATA_W-1:0] cleared, and its `msg_data` is those low bits alone.
- R4: A line that rises while its mask bit is clear sets no request bit and raises no message. Setting the mask bit later while the line stays high also sets no request bit and raises no message.
- R5: A read of the request register returns its value and clears it. A read of the pending register returns its value and clears it. Neither read changes the live register.
- R6: An edge recorded in the same cycle as a clearing read of the request register is kept. That read returns the old value, and the next read returns the new bit.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold, even if the target word is rewritten. Edges that occur while a message waits raise no further message; they are merged into the request register.
- R8: While control bit 0 is 0, rising lines set no request or pending bit and raise no message.
- R9: Writes to the request, pending and live registers are ignored. The target word reads back as written. The mask reads back as written, ANDed with 0x5FF.
- R10: A falling line sets no register bit and raises no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Interrupt lines, asynchronous |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| msg_valid | output | 1 | Message waiting |
| msg_ready | input | 1 | Receiver takes the message when high with `msg_valid` |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two functions can land in the same clock cycle: a read-and-clear of the request register, and the recording of a fresh edge into that same register. To provoke this, the bench sets an input line two cycles before the read strobe. The synchroniser delay then places the edge detection on exactly the cycle of the read. The result passes only if the read returns the previous contents and a following read returns the new bit. The bench also checks that a message was scheduled for that edge.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int LINES      = 11;
  localparam int WORD_W     = 32;
  localparam logic [LINES-1:0] IMPL_MASK = 11'h5FF;
  localparam int OFS_TARGET = 'h004;
  localparam int OFS_REQ    = 'h00C;
  localparam int OFS_MASK   = 'h018;
  localparam int OFS_PEND   = 'h01C;
  localparam int OFS_CTRL   = 'h024;
  localparam int OFS_LIVE   = 'h028;
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // STAGES must be at least 2
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irqg_capture.sv
module irqg_capture #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] mask,
  input  logic         enable,
  input  logic         clr_req,
  input  logic         clr_pend,
  output logic [W-1:0] edge_vec,
  output logic [W-1:0] req_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] prev_q;

  assign edge_vec = level & ~prev_q & mask & {W{enable}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= level;
      req_q  <= (clr_req  ? '0 : req_q)  | edge_vec;
      pend_q <= (clr_pend ? '0 : pend_q) | edge_vec;
    end
  end
endmodule

// File: rtl/irqg_msg.sv
module irqg_msg #(
  parameter int WORD_W     = 32,
  parameter int MSG_DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] target,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  localparam logic [WORD_W-1:0] LOW_MASK = (WORD_W'(1) << MSG_DATA_W) - WORD_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (fire && (!valid || ready)) begin
      valid <= 1'b1;
      addr  <= target & ~LOW_MASK;
      data  <= target & LOW_MASK;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irqg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int MSG_DATA_W  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [WORD_W-1:0] msg_addr,
  output logic [WORD_W-1:0] msg_data
);
  localparam int PAD = WORD_W - LINES;

  logic [LINES-1:0]  sync_lvl, live, edge_vec, req_q, pend_q, mask_q;
  logic [WORD_W-1:0] target_q, rd_mux;
  logic              ctrl_en, rd_hit, wr_hit, rd_req, rd_pend;

  assign rd_hit  = reg_sel && !reg_wr;
  assign wr_hit  = reg_sel && reg_wr;
  assign rd_req  = rd_hit && (reg_addr == ADDR_W'(OFS_REQ));
  assign rd_pend = rd_hit && (reg_addr == ADDR_W'(OFS_PEND));

  irqg_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_lvl)
  );

  assign live = sync_lvl & IMPL_MASK;

  irqg_capture #(.W(LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(live), .mask(mask_q),
    .enable(ctrl_en), .clr_req(rd_req), .clr_pend(rd_pend),
    .edge_vec(edge_vec), .req_q(req_q), .pend_q(pend_q)
  );

  irqg_msg #(.WORD_W(WORD_W), .MSG_DATA_W(MSG_DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .fire(|edge_vec), .target(target_q),
    .ready(msg_ready), .valid(msg_valid), .addr(msg_addr), .data(msg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      mask_q   <= '0;
      ctrl_en  <= 1'b0;
    end else if (wr_hit) begin
      if (reg_addr == ADDR_W'(OFS_TARGET)) target_q <= reg_wdata;
      if (reg_addr == ADDR_W'(OFS_MASK))   mask_q   <= reg_wdata[LINES-1:0] & IMPL_MASK;
      if (reg_addr == ADDR_W'(OFS_CTRL))   ctrl_en  <= reg_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (reg_addr == ADDR_W'(OFS_TARGET)) rd_mux = target_q;
    else if (reg_addr == ADDR_W'(OFS_REQ))    rd_mux = {{PAD{1'b0}}, req_q};
    else if (reg_addr == ADDR_W'(OFS_MASK))   rd_mux = {{PAD{1'b0}}, mask_q};
    else if (reg_addr == ADDR_W'(OFS_PEND))   rd_mux = {{PAD{1'b0}}, pend_q};
    else if (reg_addr == ADDR_W'(OFS_CTRL))   rd_mux = {{(WORD_W-1){1'b0}}, ctrl_en};
    else if (reg_addr == ADDR_W'(OFS_LIVE))   rd_mux = {{PAD{1'b0}}, live};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (rd_hit) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int W = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_en,
  input logic [W-1:0] req_q,
  input logic [W-1:0] pend_q,
  input logic         rd_req,
  input logic [31:0]  reg_rdata,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [31:0]  msg_addr,
  input logic [31:0]  msg_data
);
  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R8
  no_msg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !msg_valid) |=> !msg_valid);

  // R3
  msg_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (req_q != '0));

  // R5
  req_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (reg_rdata[W-1:0] == $past(req_q)));

  // R2
  line9_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[9] == 1'b0) && (pend_q[9] == 1'b0));
endmodule

bind irq_gather irq_gather_chk #(.W(irqg_pkg::LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .req_q(req_q), .pend_q(pend_q),
  .rd_req(rd_req), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_in = '0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic        msg_valid;
  logic        msg_ready = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];

  localparam logic [11:0] A_TGT = 12'h004, A_REQ = 12'h00C, A_MSK = 12'h018,
                          A_PND = 12'h01C, A_CTL = 12'h024, A_LIV = 12'h028;
  localparam logic [31:0] TGT = 32'h8000_0123;

  always #4 clk = ~clk;

  irq_gather u_irq_gather (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic expect_msg(input logic [31:0] word);
    exp_q.push_back({word & ~32'h1F, word & 32'h1F});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // monitor: pops an expected message at each accepted handshake
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected message addr", msg_addr, 32'hxxxx_xxxx);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check("R3 message addr", msg_addr, e[63:32]);
        check("R3 message data", msg_data, e[31:0]);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
    rd(A_TGT, 0, "R1 target"); rd(A_REQ, 0, "R1 req"); rd(A_MSK, 0, "R1 mask");
    rd(A_PND, 0, "R1 pend");   rd(A_CTL, 0, "R1 ctrl"); rd(A_LIV, 0, "R1 live");

    // R9 readback
    wr(A_TGT, TGT);      rd(A_TGT, TGT, "R9 target readback");
    wr(A_MSK, 32'h7FF);  rd(A_MSK, 32'h5FF, "R9 mask readback");

    // R8 disabled: no capture
    irq_in = 11'h001; idle(5);
    check("R8 msg_valid", {31'd0, msg_valid}, 0);
    rd(A_REQ, 0, "R8 req"); rd(A_PND, 0, "R8 pend"); rd(A_LIV, 32'h001, "R2 live while off");
    irq_in = '0; idle(5);
    wr(A_CTL, 1); rd(A_CTL, 1, "R9 ctrl readback");

    // R3 / R5 basic edge
    expect_msg(TGT);
    irq_in = 11'h004; idle(5);
    check("R3 queue drained", exp_q.size(), 0);
    rd(A_REQ, 32'h004, "R3 req"); rd(A_REQ, 0, "R5 req cleared");
    rd(A_PND, 32'h004, "R3 pend"); rd(A_PND, 0, "R5 pend cleared");
    rd(A_LIV, 32'h004, "R5 live unchanged");
    // R10 falling edge
    irq_in = '0; idle(5);
    rd(A_REQ, 0, "R10 req"); rd(A_PND, 0, "R10 pend");

    // R4 masked then unmasked
    wr(A_MSK, 32'h5F7);
    irq_in = 11'h008; idle(5);
    rd(A_LIV, 32'h008, "R2 live masked line"); rd(A_REQ, 0, "R4 req while masked");
    wr(A_MSK, 32'h5FF); idle(5);
    rd(A_REQ, 0, "R4 req after unmask"); rd(A_PND, 0, "R4 pend after unmask");
    check("R4 msg_valid", {31'd0, msg_valid}, 0);
    irq_in = '0; idle(5);

    // R2 line 9 absent, line 10 live
    expect_msg(TGT);
    irq_in = 11'h600; idle(5);
    rd(A_LIV, 32'h400, "R2 live line9"); rd(A_REQ, 32'h400, "R2 req line10");
    rd(A_PND, 32'h400, "R2 pend line10");
    irq_in = '0; idle(5);

    // R7 back-pressure and merging
    msg_ready = 1'b0;
    expect_msg(TGT);
    irq_in = 11'h001; idle(5);
    check("R7 valid held", {31'd0, msg_valid}, 1);
    irq_in = 11'h003;
    wr(A_TGT, 32'h4000_00FF); idle(5);
    check("R7 addr stable", msg_addr, 32'h8000_0120);
    check("R7 data stable", msg_data, 32'h0000_0003);
    msg_ready = 1'b1; idle(5);
    check("R7 no second message", {31'd0, msg_valid}, 0);
    check("R7 queue drained", exp_q.size(), 0);
    rd(A_REQ, 32'h003, "R7 merged req"); rd(A_PND, 32'h003, "R7 merged pend");
    wr(A_TGT, TGT);
    irq_in = '0; idle(5);

    // R6 edge in same cycle as clearing read
    expect_msg(TGT);
    irq_in = 11'h020; idle(5);
    expect_msg(TGT);
    irq_in = 11'h030;
    idle(2);
    rd(A_REQ, 32'h020, "R6 read returns old");
    rd(A_REQ, 32'h010, "R6 new edge kept");
    rd(A_PND, 32'h030, "R6 pend both");
    idle(3);

    // R9 writes ignored
    wr(A_REQ, 32'h7FF); wr(A_PND, 32'h7FF); wr(A_LIV, 32'h000);
    rd(A_REQ, 0, "R9 req write ignored"); rd(A_PND, 0, "R9 pend write ignored");
    rd(A_LIV, 32'h030, "R9 live write ignored");

    wr(A_CTL, 0); rd(A_CTL, 0, "R8 ctrl off");
    irq_in = '0; idle(5);
    check("R3 all messages seen", exp_q.size(), 0);
    done = 1'b1;
    report();
  end
endmodule